// File: doc/BRIEF.md
# Instruction Line Fetch Requester

This block sits at the front of an instruction fetch unit that serves several hardware threads. On each lookup it is given a thread id, the fetch address (the instruction PC plus whatever byte offset the fetch has advanced into a variable-length instruction) and the real instruction PC. It works out which cache line the fetch address falls in. It then reports one of three outcomes: the thread's buffered line already covers the address, a read of that line must be requested, or fetch must be held off this cycle.

Two addresses are kept apart. The line to read is taken from the offset fetch address. The interrupt hold-off test and the tag carried with the request use the real instruction PC. Each thread owns one line buffer and one outstanding request at most. A thread waits for the response, spends one cycle in an access-complete state and then runs again. A squash throws away the wait and the buffered line for its thread. A response may carry an error bit; an errored line is never marked usable.

Top module: `ifetch_line_req`

## Requirements
- R1: The line address is the fetch address with its low log2(BLOCK_BYTES) bits cleared. A request carries that line address, a size equal to BLOCK_BYTES, req_ifetch high, the real instruction PC on req_pc and the thread id on req_tid.
- R2: When the thread's buffered line is valid and its tag equals the line address, lk_ok is high in the same cycle, no request is raised and lk_line shows the buffered line.
- R3: While switched_out is high, a lookup returns lk_ok low and raises no request.
- R4: While irq_pending is high and bits [1:0] of the real instruction PC are both zero, a lookup is refused with no request. A nonzero value in those bits lets the lookup proceed.
- R5: A miss in the running state raises req_valid. The request is taken only in a cycle where req_ready is also high. Without req_ready the thread stays running and keeps its line buffer untouched.
- R6: Thread state, two bits per thread on thr_state, is encoded as 0 running, 1 waiting for a response, 2 access complete. A taken request moves the thread to 1. A lookup in state 1 or 2 is refused without a request. State 2 always returns to 0 on the next cycle.
- R7: A response (rsp_valid, rsp_tid) for a thread in state 1 stores rsp_data as that thread's line, tagged with the requested line address, and moves the thread to 2. A response for a thread that is not waiting changes nothing.
- R8: A response with rsp_err high leaves the thread's line invalid, so the next lookup of that line requests it again. fault_pulse is high for exactly the following cycle, with fault_tid naming the thread.
- R9: A squash of a thread returns it to state 0 and invalidates its line. The squash wins over a response for the same thread in the same cycle.
- R10: After reset every thread is in state 0 with no valid line.
- R11: Threads are independent: one thread waiting neither blocks nor alters another thread's hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_tid | input | TID_W | Thread of the lookup |
| lk_fetch_addr | input | ADDR_W | Fetch address (PC plus byte offset) |
| lk_inst_pc | input | ADDR_W | Real instruction PC |
| irq_pending | input | 1 | Interrupt waiting to be taken |
| switched_out | input | 1 | Fetch unit is switched out |
| lk_ok | output | 1 | Buffered line covers the fetch address |
| lk_line | output | LINE_W | Buffered line of the looked-up thread |
| req_valid | output | 1 | Line read request |
| req_ready | input | 1 | Request taken by the cache |
| req_addr | output | ADDR_W | Line-aligned read address |
| req_size | output | SIZE_W | Bytes requested |
| req_ifetch | output | 1 | Instruction-fetch attribute |
| req_pc | output | ADDR_W | Real instruction PC tag |
| req_tid | output | TID_W | Requesting thread |
| rsp_valid | input | 1 | Line response |
| rsp_tid | input | TID_W | Thread of the response |
| rsp_data | input | LINE_W | Returned line |
| rsp_err | input | 1 | Response carries a fault |
| squash | input | 1 | Squash a thread |
| squash_tid | input | TID_W | Thread being squashed |
| thr_state | output | 2*NUM_THREADS | Per-thread state, 2 bits each |
| fault_pulse | output | 1 | An errored response was taken last cycle |
| fault_tid | output | TID_W | Thread of that errored response |

## Verification
The bench sweeps fetch addresses across several lines for both threads, using a stride that does not match the line size. A sweep therefore mixes hits on a freshly filled line with misses that cross a line boundary, which shows whether the alignment mask and the tag compare are right. Some lookups put a fetch address and an instruction PC from different lines on the same lookup, to show which one selects the line and which one tags the request. Further sequences cover refusals (switched out, interrupt with and without the low PC bits set, a second lookup while waiting) and an unready cache. They also cover squashes that land during a wait, including in the same cycle as a response, errored responses, and one thread filling while the other hits.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
  typedef enum logic [1:0] {
    TS_RUN  = 2'd0,
    TS_WAIT = 2'd1,
    TS_DONE = 2'd2
  } thr_state_e;
endpackage

// File: rtl/ifr_lookup.sv
module ifr_lookup
  import ifr_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BLK_LSB = 6
) (
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [1:0]        pc_low,
  input  logic              irq_pending,
  input  logic              switched_out,
  input  thr_state_e        state,
  input  logic              held_v,
  input  logic [ADDR_W-1:0] held_tag,
  output logic [ADDR_W-1:0] line_addr,
  output logic              hold_off,
  output logic              hit,
  output logic              miss
);
  function automatic logic [ADDR_W-1:0] align_line(input logic [ADDR_W-1:0] a);
    return a & ~((ADDR_W'(1) << BLK_LSB) - ADDR_W'(1));
  endfunction

  function automatic logic privileged_pc(input logic [1:0] low);
    return low != 2'b00;
  endfunction

  always_comb begin
    line_addr = align_line(fetch_addr);
    hold_off  = switched_out || (irq_pending && !privileged_pc(pc_low)) || (state != TS_RUN);
    hit       = !hold_off && held_v && (held_tag == line_addr);
    miss      = !hold_off && !hit;
  end
endmodule

// File: rtl/ifr_thread_ctx.sv
module ifr_thread_ctx
  import ifr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [ADDR_W-1:0] issue_tag,
  input  logic              rsp_hit,
  input  logic              rsp_err,
  input  logic [LINE_W-1:0] rsp_data,
  input  logic              squash,
  output thr_state_e        state,
  output logic              held_v,
  output logic [ADDR_W-1:0] held_tag,
  output logic [LINE_W-1:0] held_line,
  output logic              rsp_take
);
  logic [ADDR_W-1:0] pend_tag;

  assign rsp_take = rsp_hit && (state == TS_WAIT) && !squash;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= TS_RUN;
      held_v    <= 1'b0;
      held_tag  <= '0;
      held_line <= '0;
      pend_tag  <= '0;
    end else if (squash) begin
      state  <= TS_RUN;
      held_v <= 1'b0;
    end else begin
      case (state)
        TS_RUN: if (issue) begin
          state    <= TS_WAIT;
          pend_tag <= issue_tag;
          held_v   <= 1'b0;
        end
        TS_WAIT: if (rsp_take) begin
          state     <= TS_DONE;
          held_tag  <= pend_tag;
          held_line <= rsp_data;
          held_v    <= !rsp_err;
        end
        default: state <= TS_RUN;
      endcase
    end
  end
endmodule

// File: rtl/ifetch_line_req.sv
module ifetch_line_req
  import ifr_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64,
  parameter int NUM_THREADS = 2,
  localparam int LINE_W     = BLOCK_BYTES * 8,
  localparam int BLK_LSB    = $clog2(BLOCK_BYTES),
  localparam int SIZE_W     = BLK_LSB + 1,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_valid,
  input  logic [TID_W-1:0]         lk_tid,
  input  logic [ADDR_W-1:0]        lk_fetch_addr,
  input  logic [ADDR_W-1:0]        lk_inst_pc,
  input  logic                     irq_pending,
  input  logic                     switched_out,
  output logic                     lk_ok,
  output logic [LINE_W-1:0]        lk_line,
  output logic                     req_valid,
  input  logic                     req_ready,
  output logic [ADDR_W-1:0]        req_addr,
  output logic [SIZE_W-1:0]        req_size,
  output logic                     req_ifetch,
  output logic [ADDR_W-1:0]        req_pc,
  output logic [TID_W-1:0]         req_tid,
  input  logic                     rsp_valid,
  input  logic [TID_W-1:0]         rsp_tid,
  input  logic [LINE_W-1:0]        rsp_data,
  input  logic                     rsp_err,
  input  logic                     squash,
  input  logic [TID_W-1:0]         squash_tid,
  output logic [2*NUM_THREADS-1:0] thr_state,
  output logic                     fault_pulse,
  output logic [TID_W-1:0]         fault_tid
);
  thr_state_e        st     [NUM_THREADS];
  logic              hv     [NUM_THREADS];
  logic [ADDR_W-1:0] tg     [NUM_THREADS];
  logic [LINE_W-1:0] ln     [NUM_THREADS];
  logic              take   [NUM_THREADS];

  logic [ADDR_W-1:0] line_addr;
  logic              hold_off;
  logic              hit;
  logic              miss;
  logic              issue_acc;

  ifr_lookup #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB)) u_lookup (
    .fetch_addr   (lk_fetch_addr),
    .pc_low       (lk_inst_pc[1:0]),
    .irq_pending  (irq_pending),
    .switched_out (switched_out),
    .state        (st[lk_tid]),
    .held_v       (hv[lk_tid]),
    .held_tag     (tg[lk_tid]),
    .line_addr    (line_addr),
    .hold_off     (hold_off),
    .hit          (hit),
    .miss         (miss)
  );

  assign lk_ok      = lk_valid && hit;
  assign lk_line    = ln[lk_tid];
  assign req_valid  = lk_valid && miss;
  assign req_addr   = line_addr;
  assign req_size   = SIZE_W'(BLOCK_BYTES);
  assign req_ifetch = 1'b1;
  assign req_pc     = lk_inst_pc;
  assign req_tid    = lk_tid;
  assign issue_acc  = req_valid && req_ready;

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thr
    ifr_thread_ctx #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_ctx (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue     (issue_acc && (lk_tid == TID_W'(g))),
      .issue_tag (line_addr),
      .rsp_hit   (rsp_valid && (rsp_tid == TID_W'(g))),
      .rsp_err   (rsp_err),
      .rsp_data  (rsp_data),
      .squash    (squash && (squash_tid == TID_W'(g))),
      .state     (st[g]),
      .held_v    (hv[g]),
      .held_tag  (tg[g]),
      .held_line (ln[g]),
      .rsp_take  (take[g])
    );
    assign thr_state[2*g +: 2] = st[g];
  end

  logic             err_any;
  logic [TID_W-1:0] err_tid;

  always_comb begin
    err_any = 1'b0;
    err_tid = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      if (take[i] && rsp_err) begin
        err_any = 1'b1;
        err_tid = TID_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_pulse <= 1'b0;
      fault_tid   <= '0;
    end else begin
      fault_pulse <= err_any;
      fault_tid   <= err_tid;
    end
  end
endmodule

// File: rtl/ifr_checker.sv
module ifr_checker #(
  parameter int ADDR_W      = 32,
  parameter int BLK_LSB     = 6,
  parameter int NUM_THREADS = 2,
  parameter int TID_W       = 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     lk_ok,
  input logic                     req_valid,
  input logic [ADDR_W-1:0]        req_addr,
  input logic [TID_W-1:0]         lk_tid,
  input logic [ADDR_W-1:0]        lk_inst_pc,
  input logic                     irq_pending,
  input logic                     switched_out,
  input logic                     squash,
  input logic [TID_W-1:0]         squash_tid,
  input logic [2*NUM_THREADS-1:0] thr_state,
  input logic                     hold_off
);
  assert_line_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[BLK_LSB-1:0] == '0));

  assert_hit_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_ok |-> !req_valid);

  assert_switched_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    switched_out |-> (!lk_ok && !req_valid && hold_off));

  assert_irq_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && lk_inst_pc[1:0] == 2'b00) |-> (!lk_ok && !req_valid));

  assert_req_only_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (thr_state[2*lk_tid +: 2] == 2'd0));

  assert_squash_to_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> (thr_state[2*$past(squash_tid) +: 2] == 2'd0));

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_chk
    assert_done_to_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_state[2*g +: 2] == 2'd2) |=> (thr_state[2*g +: 2] == 2'd0));
    assert_state_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      thr_state[2*g +: 2] != 2'd3);
  end
endmodule

bind ifetch_line_req ifr_checker #(
  .ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .NUM_THREADS(NUM_THREADS), .TID_W(TID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_ok(lk_ok), .req_valid(req_valid),
  .req_addr(req_addr), .lk_tid(lk_tid), .lk_inst_pc(lk_inst_pc),
  .irq_pending(irq_pending), .switched_out(switched_out), .squash(squash),
  .squash_tid(squash_tid), .thr_state(thr_state), .hold_off(hold_off)
);

// File: tb/ifetch_line_req_test.sv
module ifetch_line_req_test;
  localparam int AW = 12, BB = 8, NT = 2, LW = 64, SW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, lk_valid, irq_pending, switched_out, lk_ok, req_valid, req_ready;
  logic [0:0] lk_tid, req_tid, rsp_tid, squash_tid, fault_tid;
  logic [AW-1:0] lk_fetch_addr, lk_inst_pc, req_addr, req_pc;
  logic [LW-1:0] lk_line, rsp_data;
  logic [SW-1:0] req_size;
  logic req_ifetch, rsp_valid, rsp_err, squash, fault_pulse;
  logic [2*NT-1:0] thr_state;

  ifetch_line_req #(.ADDR_W(AW), .BLOCK_BYTES(BB), .NUM_THREADS(NT)) uut (.*);

  int checks = 0, fails = 0;
  bit finished = 0;
  logic          mv   [NT];
  logic [AW-1:0] mtag [NT];
  logic [LW-1:0] mline[NT];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic idle();
    lk_valid = 0; rsp_valid = 0; rsp_err = 0; squash = 0; req_ready = 0;
  endtask

  task automatic look(input int t, input int fa, input int pc);
    lk_valid = 1; lk_tid = 1'(t); lk_fetch_addr = AW'(fa); lk_inst_pc = AW'(pc); #3;
  endtask

  function automatic logic [AW-1:0] lalign(input int a);
    return AW'((a / BB) * BB);
  endfunction

  function automatic logic [LW-1:0] pat(input int a, input int t);
    return (LW'(a) * 64'h9E3779B97F4A7C15) ^ LW'(t + 1);
  endfunction

  function automatic logic [1:0] st_of(input int t);
    return thr_state[2*t +: 2];
  endfunction

  task automatic fill(input int t, input int a, input int pc);
    look(t, a, pc);
    chk(req_valid == 1, "R5 miss raises request", 64'(req_valid), 1);
    chk(req_addr == lalign(a) && req_size == SW'(BB) && req_ifetch == 1,
        "R1 request line/size/attr", 64'(req_addr), 64'(lalign(a)));
    chk(req_pc == AW'(pc) && req_tid == 1'(t), "R1 request pc/tid", 64'(req_pc), 64'(pc));
    req_ready = 1; step(); req_ready = 0; lk_valid = 0; mv[t] = 0; #1;
    chk(st_of(t) == 2'd1, "R6 waiting after issue", 64'(st_of(t)), 1);
    look(t, a, pc);
    chk(!lk_ok && !req_valid, "R6 no second request while waiting", 64'({lk_ok, req_valid}), 0);
    lk_valid = 0;
    rsp_valid = 1; rsp_tid = 1'(t); rsp_data = pat(a, t); rsp_err = 0;
    step(); rsp_valid = 0; #1;
    chk(st_of(t) == 2'd2, "R7 complete after response", 64'(st_of(t)), 2);
    look(t, a, pc);
    chk(!lk_ok && !req_valid, "R6 refused in complete", 64'({lk_ok, req_valid}), 0);
    step(); lk_valid = 0; #1;
    chk(st_of(t) == 2'd0, "R6 back to running", 64'(st_of(t)), 0);
    mv[t] = 1; mtag[t] = lalign(a); mline[t] = pat(a, t);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(); irq_pending = 0; switched_out = 0; lk_tid = 0; rsp_tid = 0; squash_tid = 0;
    lk_fetch_addr = 0; lk_inst_pc = 0; rsp_data = 0;
    for (int t = 0; t < NT; t++) begin mv[t] = 0; mtag[t] = 0; mline[t] = 0; end
    rst_n = 0; step(); step(); rst_n = 1; #1;

    // R10: reset state
    chk(thr_state == '0 && !req_valid && !lk_ok && !fault_pulse, "R10 reset state", 64'(thr_state), 0);
    look(0, 0, 1);
    chk(req_valid == 1 && !lk_ok, "R10 no valid line after reset", 64'(lk_ok), 0);
    idle();

    // R1/R2 sweep, both threads, stride not matching the line size
    for (int t = 0; t < NT; t++) begin
      for (int a = 0; a < 96; a += 5) begin
        look(t, a, a | 1);
        if (mv[t] && mtag[t] == lalign(a)) begin
          chk(lk_ok && !req_valid, "R2 hit in held line", 64'(lk_ok), 1);
          chk(lk_line == mline[t], "R2 line data", lk_line, mline[t]);
          step(); idle();
        end else begin
          idle(); fill(t, a, a | 1);
          look(t, a, a | 1);
          chk(lk_ok && lk_line == mline[t], "R2 hit after fill", lk_line, mline[t]);
          step(); idle();
        end
      end
    end

    // R1: fetch address and PC in different lines
    fill(0, 200, 13);
    look(0, 203, 190);
    chk(lk_ok == 1, "R1 line chosen by fetch address", 64'(lk_ok), 1);
    idle();

    // R3: switched out
    switched_out = 1; look(0, 200, 13);
    chk(!lk_ok && !req_valid, "R3 switched out refuses", 64'({lk_ok, req_valid}), 0);
    idle(); switched_out = 0;

    // R4: interrupt hold-off depends on pc low bits
    irq_pending = 1; look(0, 200, 12);
    chk(!lk_ok && !req_valid, "R4 irq with pc[1:0]=0 refuses", 64'({lk_ok, req_valid}), 0);
    look(0, 200, 14);
    chk(lk_ok == 1, "R4 irq with pc[1:0]!=0 proceeds", 64'(lk_ok), 1);
    idle(); irq_pending = 0;

    // R5: not ready
    look(0, 300, 301); req_ready = 0; step(); #1;
    chk(st_of(0) == 2'd0, "R5 stays running without ready", 64'(st_of(0)), 0);
    look(0, 203, 201);
    chk(lk_ok && lk_line == mline[0], "R5 buffer untouched", lk_line, mline[0]);
    idle();

    // R11: thread 1 waiting, thread 0 still hits
    fill(1, 40, 41);
    look(1, 400, 401); req_ready = 1; step(); req_ready = 0; #1;
    look(0, 201, 201);
    chk(lk_ok && lk_line == mline[0], "R11 other thread unaffected", lk_line, mline[0]);
    chk(st_of(1) == 2'd1, "R11 thread1 waiting", 64'(st_of(1)), 1);
    idle();

    // R9: squash beats same-cycle response
    squash = 1; squash_tid = 1; rsp_valid = 1; rsp_tid = 1; rsp_data = 64'hDEAD;
    step(); idle(); #1;
    chk(st_of(1) == 2'd0, "R9 squash to running", 64'(st_of(1)), 0);
    look(1, 400, 401);
    chk(req_valid && !lk_ok, "R9 squashed response not stored", 64'(lk_ok), 0);
    idle();

    // R7: late response to a non-waiting thread ignored
    rsp_valid = 1; rsp_tid = 1; rsp_data = 64'hBEEF; step(); idle(); #1;
    chk(st_of(1) == 2'd0, "R7 stray response ignored", 64'(st_of(1)), 0);
    look(1, 400, 401);
    chk(req_valid && !lk_ok, "R7 stray response no line", 64'(lk_ok), 0);
    idle();

    // R9: squash invalidates a held line
    look(0, 200, 13);
    chk(lk_ok == 1, "R9 hit before squash", 64'(lk_ok), 1);
    idle(); squash = 1; squash_tid = 0; step(); idle(); #1;
    look(0, 200, 13);
    chk(req_valid && !lk_ok, "R9 line invalid after squash", 64'(lk_ok), 0);
    idle();

    // R8: error response
    look(1, 500, 501); req_ready = 1; step(); idle();
    rsp_valid = 1; rsp_tid = 1; rsp_err = 1; rsp_data = 64'h1234; step(); idle(); #1;
    chk(fault_pulse && fault_tid == 1, "R8 fault pulse", 64'({fault_pulse, fault_tid}), 3);
    step(); #1;
    chk(!fault_pulse, "R8 fault pulse one cycle", 64'(fault_pulse), 0);
    look(1, 500, 501);
    chk(req_valid && !lk_ok, "R8 errored line re-requested", 64'(lk_ok), 0);
    idle();

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule